// File: doc/BRIEF.md
# E1 Transmit Error Injector

This block is the final stage of an E1 transmit chain. It receives the serial 2.048 Mbit/s PCM30 stream one bit per `bit_en` strobe. With each bit come its position markers: the bit number in the 256-bit frame, the frame number in the 16-frame CRC-4 multiframe, and a flag that marks frames carrying the frame alignment word. The block can corrupt the stream on purpose, and it then converts the result to HDB3 on two unipolar rails.

Software requests an error event with a one-cycle strobe. Each strobe arms a pending flag. The flag takes effect at the next matching position in the stream and then drops by itself. The event types are:
- an inverted bit in the alignment word,
- an inverted CRC bit,
- an inverted fixed bit of the non-alignment word,
- an inverted payload bit,
- a single bipolar violation,
- forcing the two E bits to zero for one multiframe.

A level input for loss of signal silences both rails and turns off the zero substitution while it is high.

Top module: `e1_err_inject`

## Requirements
- R1: During reset and after it, both rails are 0. All pending events are cleared. The first mark after reset goes on the positive rail. A bit entered at one `bit_en` appears on the rails after the fourth `bit_en` that follows.
- R2: An input one is sent as a mark. Marks alternate in polarity: rail_p=1 means positive and rail_n=1 means negative. An input zero leaves both rails at 0.
- R3: Every run of four zeros (not counting zeros already used by a substitution) is replaced. If the number of marks sent since the last substitution violation is even, the pattern is B00V. If it is odd, the pattern is 000V. B is an alternating mark and V repeats the polarity of the mark before it.
- R4: `arm_fas` inverts bit 7 of the next frame with `fas_frm`=1. Bit 0 is the first bit sent in a frame.
- R5: `arm_crc` inverts bit 0 of the next frame with `fas_frm`=1.
- R6: `arm_nfas` inverts bit 1 of the next frame with `fas_frm`=0.
- R7: `arm_pay` inverts bit 8 of the next frame, which is the first bit of timeslot 1.
- R8: `arm_ebit` takes effect at the next multiframe start (frame 0, bit 0). In that multiframe, bit 0 of frames 13 and 15 is forced to 0 when `fas_frm`=0. The event then disarms.
- R9: `arm_bpv` acts on the next one that enters while loss of signal is low, after any other corruption has been applied. That one is sent with the same polarity as the previous mark. The alternation state is left unchanged, but the mark still counts toward the parity used by R3.
- R10: While `los` is high at a `bit_en`, both rails are 0 after that enable, and no zero substitution is started.
- R11: Each event fires once per arming. A second strobe of the same type while one is already pending adds nothing.
- R12: rail_p and rail_n are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies one line bit on this cycle |
| din | input | 1 | PCM30 data bit |
| bit_idx | input | 8 | Bit number in the frame, 0 to 255 |
| frm_idx | input | 4 | Frame number in the multiframe, 0 to 15 |
| fas_frm | input | 1 | 1 when the frame carries the alignment word |
| arm_bpv | input | 1 | Strobe that arms one bipolar violation |
| arm_crc | input | 1 | Strobe that arms one CRC bit error |
| arm_fas | input | 1 | Strobe that arms one alignment word error |
| arm_nfas | input | 1 | Strobe that arms one non-alignment word error |
| arm_pay | input | 1 | Strobe that arms one payload error |
| arm_ebit | input | 1 | Strobe that arms E-bit forcing for one multiframe |
| los | input | 1 | Loss-of-signal level |
| rail_p | output | 1 | Positive mark rail |
| rail_n | output | 1 | Negative mark rail |

## Verification
The hardest situations to reach are where an armed event meets the zero-substitution state. Two examples:
- a bipolar violation that lands just after a B00V or 000V, which changes the parity for the next substitution;
- E-bit forcing that creates a new four-zero run.

The stimulus produces these by chance. It uses a sparse random data stream with about one bit in three set, so zero runs are frequent, and it strobes each event type at random times over five multiframes. Directed strobes cover the E-bit multiframe and the repeated strobe. A bench model that works on the whole bit history, with run and mark counters, predicts every rail value.

// File: rtl/e1_err_inject.sv
module e1_err_inject #(
  parameter logic [7:0] FAS_FLIP_BIT  = 8'd7,
  parameter logic [7:0] CRC_FLIP_BIT  = 8'd0,
  parameter logic [7:0] NFAS_FLIP_BIT = 8'd1,
  parameter logic [7:0] PAY_FLIP_BIT  = 8'd8,
  parameter logic [7:0] EBIT_BIT      = 8'd0,
  parameter logic [3:0] EBIT_FRM_A    = 4'd13,
  parameter logic [3:0] EBIT_FRM_B    = 4'd15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       din,
  input  logic [7:0] bit_idx,
  input  logic [3:0] frm_idx,
  input  logic       fas_frm,
  input  logic       arm_bpv,
  input  logic       arm_crc,
  input  logic       arm_fas,
  input  logic       arm_nfas,
  input  logic       arm_pay,
  input  logic       arm_ebit,
  input  logic       los,
  output logic       rail_p,
  output logic       rail_n
);
  localparam logic [1:0] C_ZERO = 2'd0;
  localparam logic [1:0] C_ONE  = 2'd1;
  localparam logic [1:0] C_B    = 2'd2;
  localparam logic [1:0] C_V    = 2'd3;

  logic p_fas, p_crc, p_nfas, p_pay, p_bpv, p_ebit, ebit_on;
  logic [1:0] s0, s1, s2, s3;
  logic [1:0] zrun;
  logic       odd;
  logic       pol;

  wire hit_fas  = p_fas  &&  fas_frm && bit_idx == FAS_FLIP_BIT;
  wire hit_crc  = p_crc  &&  fas_frm && bit_idx == CRC_FLIP_BIT;
  wire hit_nfas = p_nfas && !fas_frm && bit_idx == NFAS_FLIP_BIT;
  wire hit_pay  = p_pay  && bit_idx == PAY_FLIP_BIT;

  wire ebit_slot  = ebit_on && !fas_frm && bit_idx == EBIT_BIT &&
                    (frm_idx == EBIT_FRM_A || frm_idx == EBIT_FRM_B);
  wire ebit_last  = ebit_slot && frm_idx == EBIT_FRM_B;
  wire ebit_start = p_ebit && bit_idx == 8'd0 && frm_idx == 4'd0;

  wire flip    = hit_fas | hit_crc | hit_nfas | hit_pay;
  wire x       = ebit_slot ? 1'b0 : (din ^ flip);
  wire hit_bpv = p_bpv && x && !los;
  wire subst   = !x && zrun == 2'd3 && !los;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_fas <= 1'b0; p_crc <= 1'b0; p_nfas <= 1'b0;
      p_pay <= 1'b0; p_bpv <= 1'b0; p_ebit <= 1'b0;
      ebit_on <= 1'b0;
    end else begin
      p_fas   <= arm_fas  | (p_fas  & ~(bit_en & hit_fas));
      p_crc   <= arm_crc  | (p_crc  & ~(bit_en & hit_crc));
      p_nfas  <= arm_nfas | (p_nfas & ~(bit_en & hit_nfas));
      p_pay   <= arm_pay  | (p_pay  & ~(bit_en & hit_pay));
      p_bpv   <= arm_bpv  | (p_bpv  & ~(bit_en & hit_bpv));
      p_ebit  <= arm_ebit | (p_ebit & ~(bit_en & ebit_start));
      ebit_on <= (ebit_on & ~(bit_en & ebit_last)) | (bit_en & ebit_start);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= C_ZERO; s1 <= C_ZERO; s2 <= C_ZERO; s3 <= C_ZERO;
      zrun <= 2'd0;
      odd  <= 1'b0;
    end else if (bit_en) begin
      s0   <= (subst || hit_bpv) ? C_V : (x ? C_ONE : C_ZERO);
      s1   <= s0;
      s2   <= s1;
      s3   <= (subst && !odd) ? C_B : s2;
      odd  <= subst ? 1'b0 : (odd ^ x);
      zrun <= (x || subst || los) ? 2'd0 : zrun + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_p <= 1'b0;
      rail_n <= 1'b0;
      pol    <= 1'b0;
    end else if (bit_en) begin
      if (los) begin
        rail_p <= 1'b0;
        rail_n <= 1'b0;
      end else begin
        case (s3)
          C_ONE, C_B: begin
            rail_p <= ~pol;
            rail_n <= pol;
            pol    <= ~pol;
          end
          C_V: begin
            rail_p <= pol;
            rail_n <= ~pol;
          end
          default: begin
            rail_p <= 1'b0;
            rail_n <= 1'b0;
          end
        endcase
      end
    end
  end

  p_rails_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_p && rail_n));

  p_los_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && los |=> !rail_p && !rail_n);

  p_mark_sent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !los && s3 == C_ONE |=> rail_p ^ rail_n);

  p_viol_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !los && s3 == C_V |=> rail_p == $past(pol) && rail_n == !$past(pol));

  p_ebit_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && ebit_last |=> !ebit_on);

  p_fas_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && hit_fas && !arm_fas |=> !p_fas);

  p_bpv_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && hit_bpv && !arm_bpv |=> !p_bpv);
endmodule

// File: tb/test_e1_err_inject.sv
module test_e1_err_inject;
  localparam int NB = 16 * 256 * 5;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, din = 1'b0, fas_frm = 1'b1, los = 1'b0;
  logic [7:0] bit_idx = 8'd0;
  logic [3:0] frm_idx = 4'd0;
  logic a_bpv = 0, a_crc = 0, a_fas = 0, a_nfas = 0, a_pay = 0, a_ebit = 0;
  wire rail_p, rail_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit exp_p [NB];
  bit exp_n [NB];
  string tg [NB];

  bit m_fas, m_crc, m_nfas, m_pay, m_bpv, m_ebit, m_eon, m_dbl;
  int zr, pulses;
  bit lastp;

  always #5 clk = ~clk;

  e1_err_inject i_e1_err_inject (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din),
    .bit_idx(bit_idx), .frm_idx(frm_idx), .fas_frm(fas_frm),
    .arm_bpv(a_bpv), .arm_crc(a_crc), .arm_fas(a_fas), .arm_nfas(a_nfas),
    .arm_pay(a_pay), .arm_ebit(a_ebit), .los(los),
    .rail_p(rail_p), .rail_n(rail_n)
  );

  task automatic cmp(string t, logic gp, logic gn, bit ep, bit en);
    n_chk++;
    if (gp !== ep || gn !== en) begin
      n_bad++;
      $display("FAIL %s: rails p/n got %b%b expected %b%b at %0t", t, gp, gn, ep, en, $time);
    end
    if (gp === 1'b1 && gn === 1'b1) begin
      n_chk++; n_bad++;
      $display("FAIL R12: both rails high, got 11 expected not 11");
    end
  endtask

  function automatic void put(int i, bit p);
    exp_p[i] = p;
    exp_n[i] = !p;
  endfunction

  function automatic void model_bit(int i, bit d, int b, int f);
    bit fas = (f % 2) == 0;
    bit x = d;
    string t = "R2";
    if (m_ebit && b == 0 && f == 0) begin m_eon = 1; m_ebit = 0; end
    if (m_fas && fas && b == 7) begin x = !x; m_fas = 0; t = m_dbl ? "R11" : "R4"; m_dbl = 0; end
    if (m_crc && fas && b == 0) begin x = !x; m_crc = 0; t = "R5"; end
    if (m_nfas && !fas && b == 1) begin x = !x; m_nfas = 0; t = "R6"; end
    if (m_pay && b == 8) begin x = !x; m_pay = 0; t = "R7"; end
    if (m_eon && !fas && b == 0 && (f == 13 || f == 15)) begin
      x = 0; t = "R8";
      if (f == 15) m_eon = 0;
    end
    exp_p[i] = 0; exp_n[i] = 0;
    if (x) begin
      if (m_bpv) begin m_bpv = 0; t = "R9"; put(i, lastp); end
      else begin lastp = !lastp; put(i, lastp); end
      pulses++; zr = 0;
    end else begin
      zr++;
      if (zr == 4) begin
        if (pulses % 2 == 0) begin lastp = !lastp; put(i - 3, lastp); tg[i - 3] = "R3"; end
        put(i, lastp); t = "R3";
        pulses = 0; zr = 0;
      end
    end
    tg[i] = t;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7919);
    repeat (3) @(negedge clk);
    cmp("R1 in reset", rail_p, rail_n, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after reset", rail_p, rail_n, 0, 0);

    for (int k = 0; k < NB; k++) begin
      int b, f, r;
      @(negedge clk);
      {a_bpv, a_crc, a_fas, a_nfas, a_pay, a_ebit} = '0;
      b = k % 256;
      f = (k / 256) % 16;
      din = ($urandom % 10) < 3;
      bit_idx = 8'(b); frm_idx = 4'(f); fas_frm = (f % 2) == 0;
      model_bit(k, din, b, f);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      if (k >= 4) cmp(tg[k - 4], rail_p, rail_n, exp_p[k - 4], exp_n[k - 4]);
      else cmp("R1 pipeline fill", rail_p, rail_n, 0, 0);
      if (k == 10)  begin a_ebit = 1; m_ebit = 1; end
      if (k == 20)  begin a_bpv = 1; m_bpv = 1; end
      if (k == 600) begin a_fas = 1; m_fas = 1; end
      if (k == 700) begin a_fas = 1; m_fas = 1; m_dbl = 1; end  // R11 repeat strobe
      if (k == 30)  begin a_crc = 1; m_crc = 1; end
      if (k == 40)  begin a_pay = 1; m_pay = 1; end
      if (k == 300) begin a_nfas = 1; m_nfas = 1; end
      if (k > 800 && k < NB - 600) begin
        r = $urandom % 1500;
        case (r)
          0: begin a_fas = 1; m_fas = 1; end
          1: begin a_crc = 1; m_crc = 1; end
          2: begin a_nfas = 1; m_nfas = 1; end
          3: begin a_pay = 1; m_pay = 1; end
          4, 5: begin a_bpv = 1; m_bpv = 1; end
          6: if (k % 4 == 0) begin a_ebit = 1; m_ebit = 1; end
          default: ;
        endcase
      end
    end

    @(negedge clk);
    {a_bpv, a_crc, a_fas, a_nfas, a_pay, a_ebit} = '0;
    los = 1'b1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      din = ($urandom % 2) == 1;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      cmp("R10 loss of signal", rail_p, rail_n, 0, 0);
    end
    los = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    cmp("R1 reset after stream", rail_p, rail_n, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule